// File: doc/BRIEF.md
# Chaining Mode Wrapper for a Pipelined Block Cipher

This block sits in front of a 128-bit block-cipher core whose pipeline has a fixed latency of `LAT` cycles. It accepts plaintext blocks with a valid/ready handshake, forms the word that goes into the core, and turns the core's results into ciphertext. Four chaining modes are offered: codebook (no chaining), counter, classic chaining with the previous ciphertext, and a staggered chaining variant that keeps the core pipeline full.

A message begins with a one-cycle `start_i` pulse. That pulse latches the mode and the initial vector, and it resets the block pointers. The core sits outside the wrapper. It receives one request per cycle at most, and it returns results in order exactly `LAT` cycles later. Ciphertext leaves the wrapper in the same order as the plaintext arrived, one cycle after the core result, and is marked by `out_valid_o`.

In staggered chaining, block n is mixed with ciphertext n−LAT, so the core can take a new block on every cycle. Classic chaining has to wait for each result before it can accept the next block.

Top module: `cipher_mode_wrap`

## Requirements
- R1: `mode_i` is sampled only on a `start_i` cycle and holds until the next start. The encoding is 0 = codebook, 1 = counter, 2 = chaining, 3 = staggered chaining. Changes to `mode_i` at any other time have no effect on the output.
- R2: In codebook mode each plaintext goes unchanged to the core, and the core result is the output. A block can be accepted on every cycle.
- R3: In counter mode the core receives a counter that starts at the initial vector and increases by one per block, wrapping modulo 2^128. The output is the core result XORed with that block's plaintext. A block can be accepted on every cycle.
- R4: In chaining mode the core receives the plaintext XORed with the previous ciphertext of the message. The first block uses the initial vector instead.
- R5: In chaining mode `in_ready_o` is low from the cycle after a block is accepted until the cycle after its core result returns. Back-to-back accepted blocks are therefore exactly LAT+1 cycles apart.
- R6: In staggered chaining block n is XORed with ciphertext n−LAT, and blocks 0 to LAT−1 use the initial vector. A block can be accepted on every cycle.
- R7: Every core result produces exactly one output one cycle later. Outputs appear in the order the plaintext was accepted.
- R8: After reset the mode is codebook, `out_valid_o` and `core_req_valid_o` are low, and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a message; latches mode and initial vector |
| mode_i | input | 2 | Chaining mode for the next message |
| iv_i | input | W | Initial vector or starting counter |
| in_valid_i | input | 1 | Plaintext block offered |
| in_data_i | input | W | Plaintext block |
| in_ready_o | output | 1 | Wrapper can accept a block |
| out_valid_o | output | 1 | Ciphertext block valid |
| out_data_o | output | W | Ciphertext block |
| core_req_valid_o | output | 1 | Request to the cipher core |
| core_req_data_o | output | W | Block sent into the core |
| core_rsp_valid_i | input | 1 | Core result valid, LAT cycles after the request |
| core_rsp_data_i | input | W | Core result |

## Verification
The assertions rely on three things about the environment. The core returns each result exactly LAT cycles after its request and in order. `start_i` is pulsed only when no block is still inside the core. `start_i` and `in_valid_i` are never high in the same cycle. The bench keeps to all three: its core model is a fixed-depth shift pipeline, it waits for the message to drain before the next start, and it clears `in_valid_i` around each start pulse.

// File: rtl/cipher_mode_wrap.sv
module cipher_mode_wrap #(
  parameter int W   = 128,
  parameter int LAT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] iv_i,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o,
  output logic         core_req_valid_o,
  output logic [W-1:0] core_req_data_o,
  input  logic         core_rsp_valid_i,
  input  logic [W-1:0] core_rsp_data_i
);
  localparam int PW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [1:0] M_ECB = 2'd0, M_CTR = 2'd1, M_CBC = 2'd2, M_STG = 2'd3;
  localparam logic [PW-1:0] P_LAST = PW'(LAT - 1);

  logic [1:0]    mode_q;
  logic          busy_q;
  logic [W-1:0]  fb_q;
  logic [W-1:0]  hist_q [LAT];
  logic [PW-1:0] iptr_q, rptr_q;
  logic [W-1:0]  stag;
  logic          issue;

  assign in_ready_o       = !start_i && !(mode_q == M_CBC && busy_q);
  assign issue            = in_valid_i && in_ready_o;
  assign core_req_valid_o = issue;
  assign stag = (core_rsp_valid_i && rptr_q == iptr_q) ? core_rsp_data_i : hist_q[iptr_q];

  always_comb begin
    case (mode_q)
      M_CTR:   core_req_data_o = fb_q;
      M_CBC:   core_req_data_o = in_data_i ^ fb_q;
      M_STG:   core_req_data_o = in_data_i ^ stag;
      default: core_req_data_o = in_data_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_ECB;
      busy_q <= 1'b0;
      fb_q   <= '0;
      iptr_q <= '0;
      rptr_q <= '0;
      for (int i = 0; i < LAT; i++) hist_q[i] <= '0;
    end else if (start_i) begin
      mode_q <= mode_i;
      busy_q <= 1'b0;
      fb_q   <= iv_i;
      iptr_q <= '0;
      rptr_q <= '0;
      for (int i = 0; i < LAT; i++) hist_q[i] <= iv_i;
    end else begin
      if (issue) begin
        iptr_q <= (iptr_q == P_LAST) ? '0 : iptr_q + 1'b1;
        if (mode_q == M_CTR) begin
          fb_q           <= fb_q + 1'b1;
          hist_q[iptr_q] <= in_data_i;
        end
        if (mode_q == M_CBC) busy_q <= 1'b1;
      end
      if (core_rsp_valid_i) begin
        rptr_q <= (rptr_q == P_LAST) ? '0 : rptr_q + 1'b1;
        if (mode_q == M_CBC) begin
          fb_q   <= core_rsp_data_i;
          busy_q <= 1'b0;
        end
        if (mode_q == M_STG) hist_q[rptr_q] <= core_rsp_data_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= core_rsp_valid_i;
      out_data_o  <= (mode_q == M_CTR) ? (core_rsp_data_i ^ hist_q[rptr_q]) : core_rsp_data_i;
    end
  end
endmodule

module cipher_mode_wrap_chk #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic [1:0]   mode_q,
  input logic         in_valid_i,
  input logic [W-1:0] in_data_i,
  input logic         core_req_valid_o,
  input logic [W-1:0] core_req_data_o,
  input logic         core_rsp_valid_i,
  input logic         out_valid_o
);
  logic         have_prev;
  logic [W-1:0] prev_ctr;

  always_ff @(posedge clk) begin
    if (!rst_n || start_i) begin
      have_prev <= 1'b0;
      prev_ctr  <= '0;
    end else if (mode_q == 2'd1 && core_req_valid_o) begin
      have_prev <= 1'b1;
      prev_ctr  <= core_req_data_o;
    end
  end

  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(mode_q));

  assert_ecb_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0 && core_req_valid_o) |-> core_req_data_o == in_data_i);

  assert_ctr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd1 && core_req_valid_o && have_prev) |-> core_req_data_o == prev_ctr + 1'b1);

  assert_cbc_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2 && core_req_valid_o && !start_i) |=> !core_req_valid_o);

  assert_req_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    core_req_valid_o |-> in_valid_i);

  assert_out_follows_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    core_rsp_valid_i |=> out_valid_o);

  assert_no_spurious_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rsp_valid_i |=> !out_valid_o);
endmodule

bind cipher_mode_wrap cipher_mode_wrap_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_q(mode_q),
  .in_valid_i(in_valid_i), .in_data_i(in_data_i),
  .core_req_valid_o(core_req_valid_o), .core_req_data_o(core_req_data_o),
  .core_rsp_valid_i(core_rsp_valid_i), .out_valid_o(out_valid_o)
);

// File: tb/cipher_mode_wrap_test.sv
`timescale 1ns/1ps
module cipher_mode_wrap_test;
  localparam int W   = 128;
  localparam int LAT = 4;
  localparam logic [W-1:0] KEY = 128'h3c1f_a972_5be0_8d46_e21c_9077_b5a3_4f18;
  localparam logic [W-1:0] ADD = 128'h0f2e_4d6c_8b0a_9988_7766_5544_3322_1101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, in_valid_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [W-1:0] iv_i = '0, in_data_i = '0;
  logic in_ready_o, out_valid_o, core_req_valid_o, core_rsp_valid_i;
  logic [W-1:0] out_data_o, core_req_data_o, core_rsp_data_i;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [W-1:0] expq [$];
  string tagq [$];

  always #4 clk = ~clk;

  function automatic logic [W-1:0] enc(input logic [W-1:0] x);
    logic [W-1:0] r;
    r = {x[W-14:0], x[W-1:W-13]};
    return (r ^ KEY) + ADD;
  endfunction

  logic [W:0] pipe [LAT];
  always_ff @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < LAT; i++) pipe[i] <= '0;
    else begin
      pipe[0] <= {core_req_valid_o, enc(core_req_data_o)};
      for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    end
  end
  assign core_rsp_valid_i = pipe[LAT-1][W];
  assign core_rsp_data_i  = pipe[LAT-1][W-1:0];

  cipher_mode_wrap #(.W(W), .LAT(LAT)) uut (.*);

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid_o) begin
      if (expq.size() == 0) check(1'b0, "R7", out_data_o, '0);
      else begin
        logic [W-1:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(out_data_o == e, t, out_data_o, e);
      end
    end
  end

  function automatic logic [W-1:0] rnd();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic run_msg(input bit do_start, input logic [1:0] mode, input logic [W-1:0] iv,
                         input int nblk, input int pct, input bit toggle);
    logic [W-1:0] prev, c;
    logic [W-1:0] hist [$];
    int n = 0, cyc = 0, last = 0, stalls = 0;
    bit acc_prev = 1'b0;
    string tag;
    case (mode)
      2'd0: tag = "R2";
      2'd1: tag = "R3";
      2'd2: tag = "R4";
      default: tag = "R6";
    endcase
    if (toggle) tag = "R1";
    prev = iv;
    if (do_start) begin
      @(negedge clk); start_i = 1'b1; mode_i = mode; iv_i = iv; in_valid_i = 1'b0;
      @(negedge clk); start_i = 1'b0;
    end
    while (n < nblk) begin
      @(negedge clk);
      cyc++;
      if (toggle) mode_i = 2'($urandom());
      in_valid_i = (($urandom() % 100) < pct);
      in_data_i  = rnd();
      #1;
      if (mode == 2'd2 && acc_prev) check(in_ready_o == 1'b0, "R5", W'(in_ready_o), '0);
      if (pct == 100 && mode != 2'd2 && !in_ready_o) stalls++;
      acc_prev = in_valid_i && in_ready_o;
      if (acc_prev) begin
        case (mode)
          2'd0: c = enc(in_data_i);
          2'd1: c = enc(iv + W'(n)) ^ in_data_i;
          2'd2: begin c = enc(in_data_i ^ prev); prev = c; end
          default: begin
            c = enc(in_data_i ^ ((n < LAT) ? iv : hist[n-LAT]));
            hist.push_back(c);
          end
        endcase
        if (mode == 2'd2 && pct == 100 && n > 0) check(cyc - last == LAT + 1, "R5", W'(cyc - last), W'(LAT + 1));
        last = cyc;
        expq.push_back(c);
        tagq.push_back(tag);
        n++;
      end
    end
    @(negedge clk); in_valid_i = 1'b0;
    repeat (LAT + 4) @(negedge clk);
    check(expq.size() == 0, "R7", W'(expq.size()), '0);
    if (pct == 100 && mode != 2'd2) check(stalls == 0, tag, W'(stalls), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", '0, '0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    #1;
    check(out_valid_o == 1'b0, "R8", W'(out_valid_o), '0);
    check(core_req_valid_o == 1'b0, "R8", W'(core_req_valid_o), '0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(in_ready_o == 1'b1, "R8", W'(in_ready_o), 1);
    check(out_valid_o == 1'b0, "R8", W'(out_valid_o), '0);
    // R8: codebook is the mode after reset without any start
    run_msg(1'b0, 2'd0, '0, 3, 100, 1'b0);
    run_msg(1'b1, 2'd0, rnd(), 20, 100, 1'b0);
    run_msg(1'b1, 2'd1, rnd(), 30, 60, 1'b0);
    run_msg(1'b1, 2'd1, {W{1'b1}} - 128'd2, 10, 100, 1'b0);
    run_msg(1'b1, 2'd2, rnd(), 8, 100, 1'b0);
    run_msg(1'b1, 2'd2, rnd(), 10, 50, 1'b0);
    run_msg(1'b1, 2'd3, rnd(), 24, 100, 1'b0);
    run_msg(1'b1, 2'd3, rnd(), 40, 45, 1'b0);
    run_msg(1'b1, 2'd3, rnd(), 3, 100, 1'b0);
    // R1: mode_i wanders during messages
    run_msg(1'b1, 2'd3, rnd(), 16, 80, 1'b1);
    run_msg(1'b1, 2'd1, rnd(), 16, 80, 1'b1);
    for (int k = 0; k < 8; k++) run_msg(1'b1, 2'($urandom()), rnd(), 5 + $urandom() % 20, 30 + $urandom() % 71, 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule